// File: doc/BRIEF.md
# Ternary Fixpoint Cyclic Evaluator

This block resolves a two-gate combinational loop, X = A and not Y together with Y = B and not X, without letting it oscillate and without guessing. Each of the two loop wires is held in three-valued form (undefined, 0, 1). A start pulse captures the two primary inputs and clears both wires to undefined. After that, the block derives proven facts one per clock cycle. The order in which facts appear depends on the input values, not on a fixed topological order.

An AND-NOT node becomes 0 as soon as its direct operand is known 0 or its negated operand is known 1. It becomes 1 only when its direct operand is known 1 and its negated operand is known 0. When a cycle passes in which no new fact can be derived, the block raises a one-cycle done pulse and publishes the result. The result consists of each wire's value with a known bit, plus a constructive flag that is set only when both wires reached 0 or 1. For A = B = 1 no fact is provable, so the run ends with both wires undefined and the flag clear.

Top module: `tfp_cyclic_eval`

## Requirements
- R1: After synchronous reset, done, constructive, x_known, x_value, y_known and y_value are all 0.
- R2: If start is accepted at clock edge n and the run commits k facts, done is high for exactly one cycle, after edge n+2+k, and low otherwise.
- R3: A node is proven 0 when its direct operand is 0, whatever its negated operand is. With A=0 the X wire is therefore always resolved to 0, and a proven fact never changes within a run.
- R4: A node is proven 1 only when its direct operand is 1 and its negated operand is known 0.
- R5: For A=0, B=1 the run commits X=0 first, then Y=1. It ends with x_known=1, x_value=0, y_known=1, y_value=1, constructive=1 and k=2.
- R6: For A=1, B=0 the run commits Y=0 first, then X=1. It ends with x_value=1, y_value=0, both known bits 1, constructive=1 and k=2.
- R7: For A=0, B=0 both wires are proven 0, with both known bits 1, constructive=1 and k=2.
- R8: For A=1, B=1 no fact is derivable (k=0). done arrives after edge n+2 with constructive=0 and x_known=y_known=0. A value output whose known bit is 0 reads 0.
- R9: A start pulse is accepted only when no run is in progress. A start during a run changes neither that run's result nor its done timing, and it produces no further done pulse.
- R10: The result outputs change only at the edge that raises done, and hold their values until the done of the next accepted run.
- R11: At most one fact is committed per cycle, and X is committed before Y when both are derivable in the same cycle.
- R12: Each node keeps a pending-operand count that is loaded with 2 at start. The count drops by one when the node's input operand is taken in and by one when its peer wire is proven. It reaches 0 on both nodes in every constructive run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; samples in_a and in_b when idle |
| in_a | input | 1 | Direct operand of the X node |
| in_b | input | 1 | Direct operand of the Y node |
| done | output | 1 | One-cycle pulse when the fixpoint is reached |
| constructive | output | 1 | 1 when both wires were proven |
| x_known | output | 1 | X wire was proven |
| x_value | output | 1 | Proven value of X, 0 when unknown |
| y_known | output | 1 | Y wire was proven |
| y_value | output | 1 | Proven value of Y, 0 when unknown |

## Verification
The start edge is followed by one intake cycle, then one cycle per committed fact, then one cycle that finds no fact. done is therefore due two edges after the start edge for A=B=1 and four edges after it for every other input pair. The bench counts edges from the start edge. At every falling edge in that window it checks that done is low everywhere except in the computed cycle. It reads the result outputs in the done cycle, and before done it checks that they still hold the previous run's result. Properties check the data-dependent commit order and the pending counts, which are not visible at the ports.

// File: rtl/tfp_pkg.sv
package tfp_pkg;

    localparam int unsigned NUM_NODES  = 2;
    localparam int unsigned FANIN      = 2;
    localparam int unsigned CNT_W      = $clog2(FANIN + 1);

    // Three-valued wire: bit1 = known, bit0 = value
    typedef enum logic [1:0] {
        TV_UNDEF = 2'b00,
        TV_ZERO  = 2'b10,
        TV_ONE   = 2'b11
    } tval_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_LOAD = 2'b01,
        PH_EVAL = 2'b10
    } phase_t;

    typedef struct packed {
        logic found;
        logic value;
    } fact_t;

    typedef struct packed {
        logic x_known;
        logic x_value;
        logic y_known;
        logic y_value;
        logic constr;
    } result_t;

    function automatic logic tv_known(input tval_t t);
        return (t == TV_ZERO) || (t == TV_ONE);
    endfunction

    function automatic logic tv_bit(input tval_t t);
        return (t == TV_ONE);
    endfunction

    function automatic tval_t tv_from_bit(input logic b);
        return b ? TV_ONE : TV_ZERO;
    endfunction

    // Constructive AND-NOT: out = direct & ~negated
    function automatic fact_t andnot_derive(input tval_t direct, input tval_t negated);
        fact_t f;
        f.found = 1'b0;
        f.value = 1'b0;
        if (direct == TV_ZERO || negated == TV_ONE) begin
            f.found = 1'b1;
            f.value = 1'b0;
        end else if (direct == TV_ONE && negated == TV_ZERO) begin
            f.found = 1'b1;
            f.value = 1'b1;
        end
        return f;
    endfunction

endpackage

// File: rtl/tfp_node.sv
module tfp_node
    import tfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             intake,
    input  logic             commit,
    input  logic             peer_commit,
    input  tval_t            op_direct,
    input  tval_t            op_negated,
    output tval_t            value,
    output fact_t            cand,
    output logic [CNT_W-1:0] pending
);

    fact_t derived;
    logic [CNT_W-1:0] arrivals;

    always_comb begin
        derived = andnot_derive(op_direct, op_negated);
        if (tv_known(value)) begin
            cand.found = 1'b0;
            cand.value = 1'b0;
        end else begin
            cand = derived;
        end
    end

    always_comb begin
        arrivals = '0;
        if (intake)
            arrivals = arrivals + CNT_W'(1);
        if (peer_commit)
            arrivals = arrivals + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value   <= TV_UNDEF;
            pending <= '0;
        end else if (clear) begin
            value   <= TV_UNDEF;
            pending <= CNT_W'(FANIN);
        end else begin
            if (commit && cand.found)
                value <= tv_from_bit(cand.value);
            if (pending >= arrivals)
                pending <= pending - arrivals;
            else
                pending <= '0;
        end
    end

endmodule

// File: rtl/tfp_pick.sv
module tfp_pick #(
    parameter int unsigned N = 2
) (
    input  logic         enable,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    always_comb begin
        grant = '0;
        any   = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (enable && req[k] && !any) begin
                grant[k] = 1'b1;
                any      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tfp_seq.sv
module tfp_seq
    import tfp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   any_fact,
    output phase_t phase,
    output logic   accept,
    output logic   intake,
    output logic   eval_en,
    output logic   finish
);

    phase_t phase_nx;

    always_comb begin
        accept  = start && (phase == PH_IDLE);
        intake  = (phase == PH_LOAD);
        eval_en = (phase == PH_EVAL);
        finish  = eval_en && !any_fact;
    end

    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE: if (accept) phase_nx = PH_LOAD;
            PH_LOAD: phase_nx = PH_EVAL;
            PH_EVAL: if (finish) phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase <= PH_IDLE;
        else
            phase <= phase_nx;
    end

endmodule

// File: rtl/tfp_cyclic_eval.sv
module tfp_cyclic_eval
    import tfp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic in_a,
    input  logic in_b,
    output logic done,
    output logic constructive,
    output logic x_known,
    output logic x_value,
    output logic y_known,
    output logic y_value
);

    phase_t phase;
    logic   accept, intake, eval_en, finish, any_fact;

    logic [NUM_NODES-1:0] lat_in;
    tval_t                in_tv   [NUM_NODES];
    tval_t                node_val[NUM_NODES];
    fact_t                node_cand[NUM_NODES];
    logic [CNT_W-1:0]     node_pend[NUM_NODES];
    logic [NUM_NODES-1:0] req, grant;
    result_t              res;

    tfp_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .any_fact (any_fact),
        .phase    (phase),
        .accept   (accept),
        .intake   (intake),
        .eval_en  (eval_en),
        .finish   (finish)
    );

    always_ff @(posedge clk) begin
        if (rst)
            lat_in <= '0;
        else if (accept)
            lat_in <= {in_b, in_a};
    end

    // Node g takes input g directly and the opposite node negated
    for (genvar g = 0; g < NUM_NODES; g++) begin : g_node
        assign in_tv[g] = tv_from_bit(lat_in[g]);
        assign req[g]   = node_cand[g].found;

        tfp_node u_node (
            .clk         (clk),
            .rst         (rst),
            .clear       (accept),
            .intake      (intake),
            .commit      (grant[g]),
            .peer_commit (grant[NUM_NODES-1-g]),
            .op_direct   (in_tv[g]),
            .op_negated  (node_val[NUM_NODES-1-g]),
            .value       (node_val[g]),
            .cand        (node_cand[g]),
            .pending     (node_pend[g])
        );
    end

    tfp_pick #(.N(NUM_NODES)) u_pick (
        .enable (eval_en),
        .req    (req),
        .grant  (grant),
        .any    (any_fact)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res  <= '0;
            done <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                res.x_known <= tv_known(node_val[0]);
                res.x_value <= tv_bit(node_val[0]);
                res.y_known <= tv_known(node_val[1]);
                res.y_value <= tv_bit(node_val[1]);
                res.constr  <= tv_known(node_val[0]) && tv_known(node_val[1]);
            end
        end
    end

    assign constructive = res.constr;
    assign x_known      = res.x_known;
    assign x_value      = res.x_value;
    assign y_known      = res.y_known;
    assign y_value      = res.y_value;

endmodule

// File: rtl/tfp_checker.sv
module tfp_checker
    import tfp_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 done,
    input logic                 constructive,
    input logic                 x_known,
    input logic                 x_value,
    input logic                 y_known,
    input logic                 y_value,
    input phase_t               phase,
    input logic [NUM_NODES-1:0] grant,
    input logic [NUM_NODES-1:0] req,
    input logic [NUM_NODES-1:0] lat_in,
    input tval_t                val_x,
    input logic [CNT_W-1:0]     pend_x,
    input logic [CNT_W-1:0]     pend_y
);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_one_fact_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_x_priority_R11: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EVAL && req[0]) |-> grant[0]);

    assert_zero_rule_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EVAL && !lat_in[0] && val_x == TV_UNDEF) |-> grant[0]);

    assert_fact_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EVAL && val_x != TV_UNDEF) |=> (val_x == $past(val_x)));

    assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && start) |=> (phase != PH_LOAD));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(x_known) && $stable(x_value) && $stable(y_known)
                   && $stable(y_value) && $stable(constructive)));

    assert_noncon_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !constructive) |-> (!x_known && !y_known && !x_value && !y_value));

    assert_pend_load_R12: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD) |-> (pend_x == CNT_W'(FANIN) && pend_y == CNT_W'(FANIN)));

    assert_pend_done_R12: assert property (@(posedge clk) disable iff (rst)
        (done && constructive) |-> (pend_x == '0 && pend_y == '0));

    assert_one_rule_R4: assert property (@(posedge clk) disable iff (rst)
        (done && x_value) |-> (lat_in[0] && !y_value && y_known));

endmodule

bind tfp_cyclic_eval tfp_checker u_tfp_checker (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .done         (done),
    .constructive (constructive),
    .x_known      (x_known),
    .x_value      (x_value),
    .y_known      (y_known),
    .y_value      (y_value),
    .phase        (phase),
    .grant        (grant),
    .req          (req),
    .lat_in       (lat_in),
    .val_x        (node_val[0]),
    .pend_x       (node_pend[0]),
    .pend_y       (node_pend[1])
);

// File: tb/test_tfp_cyclic_eval.sv
`timescale 1ns/1ps
module test_tfp_cyclic_eval;

    logic clk = 1'b0;
    logic rst, start, in_a, in_b;
    logic done, constructive, x_known, x_value, y_known, y_value;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    tfp_cyclic_eval i_tfp_cyclic_eval (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .in_a         (in_a),
        .in_b         (in_b),
        .done         (done),
        .constructive (constructive),
        .x_known      (x_known),
        .x_value      (x_value),
        .y_known      (y_known),
        .y_value      (y_value)
    );

    // previous published result {constr,xk,xv,yk,yv}
    logic [4:0] prev_res;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [4:0] model(input logic a, input logic b);
        logic con;
        con = !(a && b);
        return {con, con, a & ~b, con, b & ~a};
    endfunction

    function automatic string req_of(input logic a, input logic b);
        if (!a && b) return "R5";
        if (a && !b) return "R6";
        if (!a && !b) return "R7";
        return "R8";
    endfunction

    // Run one evaluation; optionally pulse a start during the run (R9)
    task automatic run(input logic a, input logic b, input bit poke);
        logic [4:0] exp;
        int lat;
        exp = model(a, b);
        lat = (a && b) ? 2 : 4;   // R2: 2 + facts
        @(negedge clk);
        start = 1'b1; in_a = a; in_b = b;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= 7; c++) begin
            if (poke && c == 1) begin
                start = 1'b1; in_a = ~a; in_b = ~b;
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            check(c == lat ? "R2" : (poke ? "R9" : "R2"), done, c == lat);
            if (c < lat)
                check("R10", {constructive, x_known, x_value, y_known, y_value}, prev_res);
            if (c == lat) begin
                check(req_of(a, b), {constructive, x_known, x_value, y_known, y_value}, exp);
                if (!a) check("R3", {x_known, x_value}, 2'b10);
                if (x_value) check("R4", {a, y_known, y_value}, 3'b110);
            end
        end
        check("R10", {constructive, x_known, x_value, y_known, y_value}, exp);
        prev_res = exp;
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; in_a = 1'b0; in_b = 1'b0;
        prev_res = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {done, constructive, x_known, x_value, y_known, y_value}, 0);

        // exhaustive sweep, several orders, with and without busy starts
        for (int rep = 0; rep < 3; rep++) begin
            for (int v = 0; v < 4; v++) begin
                int p;
                p = (v + rep) % 4;
                run(p[0], p[1], 1'b0);
            end
        end
        for (int v = 0; v < 4; v++)
            run(v[0], v[1], 1'b1);
        run(1'b1, 1'b1, 1'b0);
        run(1'b1, 1'b1, 1'b0);
        run(1'b0, 1'b1, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule